// File: doc/BRIEF.md
# Bus Access Watchpoint Comparator

This block watches the accesses of a CPU bus with a 16-bit data path and flags any access that meets a programmed condition. Software loads the condition through a small write port. The condition is made of a target address, an expected data word split into an even-address byte and an odd-address byte, and a mask for each of those bytes. Optional qualifiers restrict the match to one transfer direction, or to opcode fetches only. The block reports a one-clock match pulse and a sticky hit flag. The flag stays set until software clears it.

Only exact equality is supported. The access width is never part of the decision. An opcode fetch is judged on its word-aligned address, so a fetch at an odd address n is caught by programming n-1. Opcode matches are reported on the fetch cycle, not on execution. When an external range-mode flag hands the comparator over to trace-range duty, it produces no bus matches at all.

Top module: `dbg_bus_cmp`

## Requirements
- R1: After reset, every configuration register is zero and the comparator is disabled. While disabled, no bus cycle produces a match, and both `match_o` and `hit_o` read 0.
- R2: `match_o` is registered. It is high for exactly the one clock that follows a qualifying bus cycle. It only rises when `bus_valid_i` and the enable bit were both high in that cycle.
- R3: The address test is exact equality between `bus_addr_i` and the programmed address. While data compare is off, the data and mask registers have no effect.
- R4: With data compare on, `bus_data_i[15:8]` carries the byte at the even (lower) address and is tested against the high data byte. `bus_data_i[7:0]` carries the byte at address+1 and is tested against the low data byte. A mask bit of 1 compares that bit and a mask bit of 0 ignores it.
- R5: `bus_size_word_i` never changes the match decision. A byte compare is made by loading the high data byte and clearing the low mask byte.
- R6: A word access at address n can reach the n+1 byte through address n, the low data byte and a high mask of 0x00. The same word access does not match a comparator programmed with n+1.
- R7: During an opcode fetch (`bus_opfetch_i`=1), the address test uses the fetch address with bit 0 cleared, so a fetch at odd n matches a programmed n-1. A non-fetch access at odd n does not match n-1.
- R8: When the opcode-only qualifier is set, only cycles with `bus_opfetch_i`=1 can match.
- R9: When the direction qualifier is set, only cycles whose `bus_read_i` equals the direction-select bit can match (1 = reads, 0 = writes). When it is clear, either direction can match.
- R10: While `range_own_i` is high, the comparator produces no match, even if the bus cycle meets the programmed condition.
- R11: `hit_o` rises together with `match_o` and stays high until a cycle with `hit_clr_i`=1. If the clear and a qualifying bus cycle fall in the same cycle, the flag stays set.
- R12: A write with `cfg_we_i`=1 takes effect on the next clock. `cfg_sel_i` picks the target: 0 selects control, 1 the address, 2 the data word {high,low} and 3 the mask word {high,low}. Control bits are: bit0 enable, bit1 data compare, bit2 direction qualifier, bit3 direction select (1 = read), bit4 opcode-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | CFG_W (16) | Configuration write data |
| hit_clr_i | input | 1 | Clears the sticky hit flag |
| bus_valid_i | input | 1 | Bus cycle valid strobe |
| bus_addr_i | input | ADDR_W (16) | Bus address |
| bus_data_i | input | LANES*8 (16) | Bus data, even-address byte in the upper lane |
| bus_read_i | input | 1 | 1 = read, 0 = write |
| bus_size_word_i | input | 1 | 1 = word access, 0 = byte access |
| bus_opfetch_i | input | 1 | Cycle is an opcode fetch |
| range_own_i | input | 1 | Comparator is assigned to trace-range duty |
| match_o | output | 1 | One-clock match pulse |
| hit_o | output | 1 | Sticky hit flag |

## Verification
Two functions can meet in one cycle: software clearing the sticky flag, and a new qualifying bus cycle setting it. The bench provokes this by raising `hit_clr_i` in the same cycle that it presents a matching access. It judges the outcome by checking that `hit_o` is still high at the next sample and that `match_o` pulses. It also checks the plain clear on its own, and confirms that the flag then drops one clock later.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;

  localparam int BYTE_W = 8;

  // Register select codes on the configuration port
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_MASK = 2'd3;

  localparam int CTRL_W = 5;

  // Control word; the last field listed is bit 0
  typedef struct packed {
    logic op_only;   // bit4
    logic dir_read;  // bit3
    logic dir_en;    // bit2
    logic data_en;   // bit1
    logic enable;    // bit0
  } ctrl_t;

endpackage

// File: rtl/dbg_cmp_regs.sv
module dbg_cmp_regs
  import dbg_cmp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [CFG_W-1:0]  wdata,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] mask
);

  // Upper write-data bits beyond a register's width are dropped
  wire unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      addr <= '0;
      data <= '0;
      mask <= '0;
    end else if (we) begin
      case (sel)
        SEL_CTRL: ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        SEL_ADDR: addr <= wdata[ADDR_W-1:0];
        SEL_DATA: data <= wdata[DATA_W-1:0];
        default:  mask <= wdata[DATA_W-1:0];
      endcase
    end
  end

endmodule

// File: rtl/dbg_cmp_lane.sv
module dbg_cmp_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] bus_b,
  input  logic [W-1:0] ref_b,
  input  logic [W-1:0] mask_b,
  output logic         ok
);

  // Only bits with a set mask bit take part in the compare
  always_comb ok = ~|((bus_b ^ ref_b) & mask_b);

endmodule

// File: rtl/dbg_cmp_core.sv
module dbg_cmp_core
  import dbg_cmp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrl_t                    ctrl,
  input  logic [ADDR_W-1:0]        ref_addr,
  input  logic [LANES*BYTE_W-1:0]  ref_data,
  input  logic [LANES*BYTE_W-1:0]  ref_mask,
  input  logic                     hit_clr,
  input  logic                     bus_valid,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [LANES*BYTE_W-1:0]  bus_data,
  input  logic                     bus_read,
  input  logic                     bus_opfetch,
  input  logic                     range_own,
  output logic                     match_q,
  output logic                     hit_q
);

  localparam int DATA_W = LANES * BYTE_W;

  logic [LANES-1:0]  lane_ok;
  logic [ADDR_W-1:0] eff_addr;
  logic              addr_ok, data_ok, dir_ok, tag_ok, hit_c;

  // Lane 0 is the even-address byte and sits in the top bits of the bus
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dbg_cmp_lane #(.W(BYTE_W)) u_lane (
      .bus_b (bus_data[DATA_W-1-BYTE_W*i -: BYTE_W]),
      .ref_b (ref_data[DATA_W-1-BYTE_W*i -: BYTE_W]),
      .mask_b(ref_mask[DATA_W-1-BYTE_W*i -: BYTE_W]),
      .ok    (lane_ok[i])
    );
  end

  always_comb begin
    // Fetches are judged on their word-aligned address
    eff_addr = bus_opfetch ? {bus_addr[ADDR_W-1:1], 1'b0} : bus_addr;
    addr_ok  = (eff_addr == ref_addr);
    data_ok  = !ctrl.data_en || (&lane_ok);
    dir_ok   = !ctrl.dir_en || (bus_read == ctrl.dir_read);
    tag_ok   = !ctrl.op_only || bus_opfetch;
    hit_c    = ctrl.enable && !range_own && bus_valid &&
               addr_ok && data_ok && dir_ok && tag_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      match_q <= hit_c;
      // A new hit outranks a clear arriving in the same cycle
      hit_q   <= hit_c || (hit_q && !hit_clr);
    end
  end

  assert_match_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && ctrl.enable) |=> !match_q);

  assert_range_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    range_own |=> !match_q);

  assert_hit_holds_R11: assert property (@(posedge clk) disable iff (rst)
    hit_q && !hit_clr |=> hit_q);

  assert_match_sets_hit_R11: assert property (@(posedge clk) disable iff (rst)
    match_q |-> hit_q);

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !ctrl.enable |=> !match_q);

endmodule

// File: rtl/dbg_bus_cmp.sv
module dbg_bus_cmp
  import dbg_cmp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2,
  parameter int CFG_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we_i,
  input  logic [1:0]              cfg_sel_i,
  input  logic [CFG_W-1:0]        cfg_wdata_i,
  input  logic                    hit_clr_i,
  input  logic                    bus_valid_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [LANES*8-1:0]      bus_data_i,
  input  logic                    bus_read_i,
  input  logic                    bus_size_word_i,
  input  logic                    bus_opfetch_i,
  input  logic                    range_own_i,
  output logic                    match_o,
  output logic                    hit_o
);

  localparam int DATA_W = LANES * BYTE_W;

  ctrl_t              ctrl;
  logic [ADDR_W-1:0]  ref_addr;
  logic [DATA_W-1:0]  ref_data, ref_mask;

  // Access width is deliberately left out of the match decision
  wire unused_size = bus_size_word_i;

  dbg_cmp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we_i),
    .sel  (cfg_sel_i),
    .wdata(cfg_wdata_i),
    .ctrl (ctrl),
    .addr (ref_addr),
    .data (ref_data),
    .mask (ref_mask)
  );

  dbg_cmp_core #(.ADDR_W(ADDR_W), .LANES(LANES)) u_core (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .ref_addr   (ref_addr),
    .ref_data   (ref_data),
    .ref_mask   (ref_mask),
    .hit_clr    (hit_clr_i),
    .bus_valid  (bus_valid_i),
    .bus_addr   (bus_addr_i),
    .bus_data   (bus_data_i),
    .bus_read   (bus_read_i),
    .bus_opfetch(bus_opfetch_i),
    .range_own  (range_own_i),
    .match_q    (match_o),
    .hit_q      (hit_o)
  );

endmodule

// File: tb/dbg_bus_cmp_test.sv
`timescale 1ns/1ps
module dbg_bus_cmp_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        hit_clr = 1'b0;
  logic        bus_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic        bus_read = 1'b0;
  logic        bus_word = 1'b0;
  logic        bus_op = 1'b0;
  logic        range_own = 1'b0;
  logic        match, hit;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dbg_bus_cmp uut (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .hit_clr_i(hit_clr), .bus_valid_i(bus_valid),
    .bus_addr_i(bus_addr), .bus_data_i(bus_data), .bus_read_i(bus_read),
    .bus_size_word_i(bus_word), .bus_opfetch_i(bus_op), .range_own_i(range_own),
    .match_o(match), .hit_o(hit)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One bus cycle, then the match sample one clock later, then an idle cycle
  task automatic probe(input string req, input logic [15:0] a, input logic [15:0] d,
                       input logic rd, input logic wd, input logic op, input logic exp);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_data = d;
    bus_read = rd; bus_word = wd; bus_op = op;
    @(negedge clk);
    bus_valid = 1'b0; bus_op = 1'b0;
    check(req, match, exp);
    @(negedge clk);
    check({req, " pulse ends"}, match, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 match after reset", match, 1'b0);
    check("R1 hit after reset", hit, 1'b0);
    // Registers are zero, so address 0 would match if the block were enabled
    probe("R1 disabled ignores bus", 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_addr;
    wr(2'd2, 16'hDEAD);        // R12 data select
    wr(2'd3, 16'hFFFF);        // R12 mask select
    wr(2'd1, 16'h1234);        // R12 address select
    wr(2'd0, 16'h0001);        // R12 enable only
    probe("R3 exact address", 16'h1234, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1);
    probe("R3 other address", 16'h1236, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0);
    // Valid low with matching address must not match (R2)
    @(negedge clk);
    bus_addr = 16'h1234; bus_valid = 1'b0;
    @(negedge clk);
    check("R2 no valid no match", match, 1'b0);
  endtask

  task automatic t_word_data;
    wr(2'd1, 16'h2000);
    wr(2'd2, 16'hA55A);
    wr(2'd3, 16'hFFFF);
    wr(2'd0, 16'h0003);
    probe("R4 word data equal", 16'h2000, 16'hA55A, 1'b0, 1'b1, 1'b0, 1'b1);
    probe("R4 low lane differs", 16'h2000, 16'hA55B, 1'b0, 1'b1, 1'b0, 1'b0);
    probe("R4 high lane differs", 16'h2000, 16'hB55A, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_byte;
    wr(2'd2, 16'h3C00);
    wr(2'd3, 16'hFF00);
    probe("R5 byte compare", 16'h2000, 16'h3C77, 1'b1, 1'b0, 1'b0, 1'b1);
    probe("R5 word same data", 16'h2000, 16'h3C77, 1'b1, 1'b1, 1'b0, 1'b1);
    probe("R5 byte mismatch", 16'h2000, 16'h3D77, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_upper_byte;
    wr(2'd1, 16'h3000);
    wr(2'd2, 16'h00C3);
    wr(2'd3, 16'h00FF);
    probe("R6 n+1 byte via word", 16'h3000, 16'h11C3, 1'b0, 1'b1, 1'b0, 1'b1);
    probe("R6 n+1 byte wrong", 16'h3000, 16'h11C4, 1'b0, 1'b1, 1'b0, 1'b0);
    wr(2'd1, 16'h3001);
    probe("R6 n+1 address not on bus", 16'h3000, 16'h11C3, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_opcode;
    wr(2'd1, 16'h4000);
    wr(2'd0, 16'h0001);
    probe("R7 odd fetch matches n-1", 16'h4001, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1);
    probe("R7 odd data read no match", 16'h4001, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_tag;
    wr(2'd0, 16'h0011);
    probe("R8 fetch matches", 16'h4000, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1);
    probe("R8 data access blocked", 16'h4000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_dir;
    wr(2'd0, 16'h000D);        // enable, direction qualifier, reads
    probe("R9 read accepted", 16'h4000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1);
    probe("R9 write rejected", 16'h4000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);
    wr(2'd0, 16'h0005);        // enable, direction qualifier, writes
    probe("R9 write accepted", 16'h4000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1);
    probe("R9 read rejected", 16'h4000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_range;
    wr(2'd0, 16'h0001);
    range_own = 1'b1;
    probe("R10 range duty blocks", 16'h4000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0);
    range_own = 1'b0;
    probe("R10 released matches", 16'h4000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_sticky;
    @(negedge clk); hit_clr = 1'b1;
    @(negedge clk); hit_clr = 1'b0;
    check("R11 cleared", hit, 1'b0);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 16'h4000;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R11 set with match", hit, 1'b1);
    repeat (3) @(negedge clk);
    check("R11 holds", hit, 1'b1);
    // Clear and new hit in the same cycle: set wins
    bus_valid = 1'b1; hit_clr = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; hit_clr = 1'b0;
    check("R11 set beats clear", hit, 1'b1);
    check("R11 match with clear", match, 1'b1);
    hit_clr = 1'b1;
    @(negedge clk);
    hit_clr = 1'b0;
    check("R11 clear alone", hit, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_addr();
    t_word_data();
    t_byte();
    t_upper_byte();
    t_opcode();
    t_tag();
    t_dir();
    t_range();
    t_sticky();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule